// File: doc/BRIEF.md
# Processor General Register Bank with Program Counter

This block holds the sixteen 32-bit architectural registers of a 32-bit processor core. Two combinational read ports return the contents of any two registers, selected by index. One clocked write port stores a data word into one indexed register when its enable is high. The highest-numbered register is the program counter. On every rising clock edge it reloads from a dedicated next-PC input, whether or not the write port is active.

Every stored register is also driven onto a wide debug view. This lets a surrounding processor or a bench inspect the whole architectural state on every cycle. A synchronous active-high reset clears the whole bank, including the program counter. Reads do not bypass the write path. A register written on a given edge shows its new value only after that edge.

Top module: `gpr_bank_pc`

## Requirements
- R1: While `rst` is high at a rising edge, all sixteen registers, including the program counter at index 15, become zero after that edge.
- R2: At a rising edge with `rst` low, `wr_en` high and `wr_idx` in 0..14, the register at `wr_idx` takes the value of `wr_data`.
- R3: At a rising edge with `rst` low and `wr_en` low, registers 0..14 keep their values.
- R4: At every rising edge with `rst` low, register 15 takes the value of `pc_next`, whatever `wr_en` and `wr_idx` are.
- R5: When `wr_en` is high and `wr_idx` equals 15, register 15 still takes `pc_next`, `wr_data` is ignored, and registers 0..14 keep their values.
- R6: `rd_a_data` always equals the current contents of the register selected by `rd_a_idx`, with no clock delay.
- R7: `rd_b_data` always equals the current contents of the register selected by `rd_b_idx`, with no clock delay.
- R8: A read of a register whose write is pending returns the old value until the edge, because reads are not bypassed.
- R9: A read of index 15 on either port returns the stored program counter with no offset added.
- R10: Slice i of `dbg_regs` (bits 32*i+31 down to 32*i) always shows register i, for i in 0..15.
- R11: A write through the write port changes only the addressed register among 0..14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable for the general write port |
| wr_idx | input | 4 | Index of the register to write |
| wr_data | input | 32 | Data to write |
| pc_next | input | 32 | Value that register 15 loads on every edge |
| rd_a_idx | input | 4 | Index for read port A |
| rd_a_data | output | 32 | Contents of the register selected on port A |
| rd_b_idx | input | 4 | Index for read port B |
| rd_b_data | output | 32 | Contents of the register selected on port B |
| dbg_regs | output | 512 | All sixteen registers, register i in slice i |

## Verification
On every cycle the assertions check the edge behaviour of each register: the reset clear, the load on an addressed write, the hold when a register is not written, and the program counter following `pc_next` even when the write port targets index 15. They also check that both read ports agree with the debug view for the selected index. Only the bench scenarios can show that the right value reaches the right register slot across a sweep of all indices. They also show the absence of bypass on a same-cycle read of a pending write, and that a reset in the middle of a run wipes state written earlier.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_IDX_W  = 4;

    // Kind of update one storage slot performs at the next edge.
    typedef enum logic [1:0] {
        LOAD_KEEP = 2'd0,
        LOAD_WORD = 2'd1,
        LOAD_PC   = 2'd2,
        LOAD_CLR  = 2'd3
    } load_kind_e;

    // Chooses the update of one slot. Reset has priority, then the
    // program-counter reload, then the general write.
    function automatic load_kind_e pick_load(input logic clr,
                                             input logic is_pc,
                                             input logic hit);
        if (clr)
            return LOAD_CLR;
        else if (is_pc)
            return LOAD_PC;
        else if (hit)
            return LOAD_WORD;
        else
            return LOAD_KEEP;
    endfunction

endpackage

// File: rtl/regbank_wr_decode.sv
module regbank_wr_decode #(
    parameter int unsigned IDX_W = regbank_pkg::DEF_IDX_W,
    localparam int unsigned NREG = 1 << IDX_W
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [NREG-1:0]  hit_o
);

    localparam int unsigned PC_IDX = NREG - 1;

    // One-hot select for the general write. The program-counter slot never
    // takes a general write, so an index of PC_IDX selects nothing.
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        if (i == PC_IDX) begin : g_pc
            assign hit_o[i] = 1'b0;
        end else begin : g_gpr
            assign hit_o[i] = wr_en && (wr_idx == IDX_W'(i));
        end
    end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
    parameter int unsigned DATA_W = regbank_pkg::DEF_DATA_W,
    parameter int unsigned IDX_W  = regbank_pkg::DEF_IDX_W,
    localparam int unsigned NREG  = 1 << IDX_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NREG-1:0]              hit_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic [DATA_W-1:0]            pc_next_i,
    output logic [NREG-1:0][DATA_W-1:0]  q_o
);

    import regbank_pkg::*;

    localparam int unsigned PC_IDX = NREG - 1;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        load_kind_e kind;

        always_comb begin
            kind = pick_load(rst, (i == PC_IDX), hit_i[i]);
        end

        always_ff @(posedge clk) begin
            case (kind)
                LOAD_CLR:  q_o[i] <= '0;
                LOAD_PC:   q_o[i] <= pc_next_i;
                LOAD_WORD: q_o[i] <= wr_data_i;
                default:   q_o[i] <= q_o[i];
            endcase
        end

        // R1: reset clears every slot
        p_clear_r1: assert property (@(posedge clk)
            rst |=> (q_o[i] == '0));

        if (i == PC_IDX) begin : g_pc_chk
            // R4: the program counter follows its own input every edge
            p_pc_follow_r4: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (q_o[i] == $past(pc_next_i)));
        end else begin : g_gpr_chk
            // R2: a selected slot loads the write data
            p_load_r2: assert property (@(posedge clk) disable iff (rst)
                hit_i[i] |=> (q_o[i] == $past(wr_data_i)));
            // R3 / R11: an unselected slot holds
            p_hold_r3: assert property (@(posedge clk) disable iff (rst)
                !hit_i[i] |=> $stable(q_o[i]));
        end
    end

endmodule

// File: rtl/regbank_read_mux.sv
module regbank_read_mux #(
    parameter int unsigned DATA_W = regbank_pkg::DEF_DATA_W,
    parameter int unsigned IDX_W  = regbank_pkg::DEF_IDX_W,
    localparam int unsigned NREG  = 1 << IDX_W
) (
    input  logic [NREG-1:0][DATA_W-1:0] regs_i,
    input  logic [IDX_W-1:0]            idx_i,
    output logic [DATA_W-1:0]           data_o
);

    // Plain index select. No bypass path and no offset on the PC slot.
    always_comb begin
        data_o = regs_i[idx_i];
    end

endmodule

// File: rtl/gpr_bank_pc.sv
module gpr_bank_pc #(
    parameter int unsigned DATA_W = regbank_pkg::DEF_DATA_W,
    parameter int unsigned IDX_W  = regbank_pkg::DEF_IDX_W,
    localparam int unsigned NREG  = 1 << IDX_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [DATA_W-1:0]           pc_next,
    input  logic [IDX_W-1:0]            rd_a_idx,
    output logic [DATA_W-1:0]           rd_a_data,
    input  logic [IDX_W-1:0]            rd_b_idx,
    output logic [DATA_W-1:0]           rd_b_data,
    output logic [NREG-1:0][DATA_W-1:0] dbg_regs
);

    localparam int unsigned PC_IDX = NREG - 1;
    localparam int unsigned NPORT  = 2;

    logic [NREG-1:0]             hit;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic [NPORT-1:0][IDX_W-1:0] port_idx;
    logic [NPORT-1:0][DATA_W-1:0] port_data;

    regbank_wr_decode #(.IDX_W(IDX_W)) u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .hit_o  (hit)
    );

    regbank_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .hit_i     (hit),
        .wr_data_i (wr_data),
        .pc_next_i (pc_next),
        .q_o       (regs)
    );

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        regbank_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
            .regs_i (regs),
            .idx_i  (port_idx[p]),
            .data_o (port_data[p])
        );
    end

    assign rd_a_data = port_data[0];
    assign rd_b_data = port_data[1];
    assign dbg_regs  = regs;

    // R6: port A agrees with the debug view
    p_port_a_r6: assert property (@(posedge clk) disable iff (rst)
        rd_a_data == dbg_regs[rd_a_idx]);
    // R7: port B agrees with the debug view
    p_port_b_r7: assert property (@(posedge clk) disable iff (rst)
        rd_b_data == dbg_regs[rd_b_idx]);
    // R5: a general write aimed at the PC index loses to pc_next
    p_pc_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_W'(PC_IDX)) |=> (dbg_regs[PC_IDX] == $past(pc_next)));
    // R11: at most one general slot is selected
    p_one_hit_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

endmodule

// File: tb/tb_gpr_bank_pc.sv
module tb_gpr_bank_pc;

    localparam int NREG = 16;

    typedef struct {
        logic [31:0] regs [NREG];
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_idx = '0, rd_a_idx = '0, rd_b_idx = '0;
    logic [31:0] wr_data = '0, pc_next = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic [NREG-1:0][31:0] dbg_regs;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model [NREG];
    exp_t sb [$];

    always #2 clk = ~clk;

    gpr_bank_pc dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_next(pc_next), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .dbg_regs(dbg_regs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, checks the pre-edge reads
    // against the model, and queues the state expected after the edge.
    task automatic op(input logic r, input logic en, input logic [3:0] wi,
                      input logic [31:0] wd, input logic [31:0] pc,
                      input logic [3:0] ra, input logic [3:0] rb, input string req);
        exp_t e;
        @(negedge clk);
        rst = r; wr_en = en; wr_idx = wi; wr_data = wd; pc_next = pc;
        rd_a_idx = ra; rd_b_idx = rb;
        #1;
        check({req, " R6 port A"}, rd_a_data, model[ra]);
        check({req, " R7 port B"}, rd_b_data, model[rb]);
        for (int i = 0; i < NREG; i++) e.regs[i] = model[i];
        if (r) begin
            for (int i = 0; i < NREG; i++) e.regs[i] = '0;
        end else begin
            if (en && wi != 4'd15) e.regs[wi] = wd;
            e.regs[15] = pc;
        end
        e.req = req;
        sb.push_back(e);
        for (int i = 0; i < NREG; i++) model[i] = e.regs[i];
    endtask

    // Monitor: after each edge, compares the debug view with the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                for (int i = 0; i < NREG; i++) begin
                    checks++;
                    if (dbg_regs[i] !== e.regs[i]) begin
                        failures++;
                        $display("FAIL %s R10 reg %0d actual=%h expected=%h",
                                 e.req, i, dbg_regs[i], e.regs[i]);
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        // R1: reset state; the PC input is ignored under reset
        op(1'b1, 1'b1, 4'd2, 32'hDEAD0002, 32'h1234_5678, 4'd2, 4'd15, "R1 reset");
        op(1'b1, 1'b0, 4'd0, 32'h0, 32'h0000_0040, 4'd0, 4'd15, "R1 reset");
        // R2 / R4 / R11: fill r0..r14 while the PC advances
        for (int i = 0; i < 15; i++)
            op(1'b0, 1'b1, 4'(i), 32'hA5000000 + 32'(i * 32'h01010101), 32'h1000 + 32'(4 * i),
               4'(i), 4'd15, "R2 R4 R11 fill");
        // R3: write enable low with garbage data leaves r0..r14 alone
        op(1'b0, 1'b0, 4'd7, 32'hFFFF_FFFF, 32'h2000, 4'd7, 4'd8, "R3 hold");
        op(1'b0, 1'b0, 4'd0, 32'h0BAD_0BAD, 32'h2004, 4'd0, 4'd14, "R3 hold");
        // R5: write aimed at index 15 loses to pc_next
        op(1'b0, 1'b1, 4'd15, 32'hCAFE_F00D, 32'h3000, 4'd15, 4'd15, "R5 pc wins");
        op(1'b0, 1'b0, 4'd1, 32'h0, 32'h3004, 4'd15, 4'd1, "R5 R9 pc read");
        // R8: same-cycle read of a pending write returns the old value
        op(1'b0, 1'b1, 4'd3, 32'h3333_3333, 32'h3008, 4'd3, 4'd3, "R8 no bypass");
        op(1'b0, 1'b0, 4'd3, 32'h0, 32'h300C, 4'd3, 4'd15, "R8 after edge");
        // R6 / R7 / R9: sweep all indices on both ports
        for (int i = 0; i < NREG; i++)
            op(1'b0, 1'b0, 4'd0, 32'h0, 32'h4000 + 32'(i), 4'(i), 4'(15 - i), "R6 R7 R9 sweep");
        // R11: overwrite r0 and r14 (index edges)
        op(1'b0, 1'b1, 4'd0, 32'h0000_0001, 32'h5000, 4'd0, 4'd14, "R11 edge write");
        op(1'b0, 1'b1, 4'd14, 32'h8000_0000, 32'h5004, 4'd14, 4'd0, "R11 edge write");
        // R1: reset in the middle of a run
        op(1'b1, 1'b1, 4'd5, 32'h5555_5555, 32'h6000, 4'd5, 4'd15, "R1 mid reset");
        op(1'b0, 1'b0, 4'd5, 32'h0, 32'h6004, 4'd5, 4'd15, "R1 R4 after reset");
        @(negedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule